// File: doc/BRIEF.md
# Count/Compare Timer with Routed Interrupt

This block is a free-running timer meant to sit beside a processor core as a system-control register set. A 32-bit count register advances by one on each pulse of an internal prescaler and is compared with a compare register that software writes. When the count reaches the compare value, the timer raises one of eight interrupt lines and can also record a pending flag in a cause register. Software acknowledges the interrupt by writing the compare register.

A freeze bit in the cause register stops the counter. While the bit is set, the count value is held and reads return it. No match can fire. When the bit is cleared, counting resumes from the held value. A 3-bit field in an interrupt-control register selects the target line. A revision-select input decides whether the cause register's pending flag takes part in raising and acknowledging the interrupt. The line itself is raised and lowered for every revision.

Software uses a single-cycle register port with a 2-bit address: 0 is count, 1 is compare, 2 is cause and 3 is interrupt control. Reads are combinational. A write lands on the next clock edge.

Top module: `cct_timer`

## Requirements
- R1: During and after reset, count, compare, cause and interrupt-control all read 0, and all interrupt lines are low.
- R2: While not frozen, count increments by exactly one once every PRESCALE_DIV clock cycles (4 by default) and wraps from 0xFFFFFFFF to 0.
- R3: A write to address 0 sets count to the written value on the next edge, taking priority over a prescaler increment in the same cycle.
- R4: While cause bit 1 (freeze) is set, count does not advance, and reads at address 0 return the held value.
- R5: After freeze is cleared, count reads the held value and then advances at the normal rate, with no jump for the time spent frozen.
- R6: While freeze is set, a count/compare match sets no pending flag and raises no line.
- R7: When an increment makes count equal to compare, the routed line rises on that same edge. It stays high until the next write to address 1.
- R8: A match sets cause bit 0 only when rev_sel equals 1. For any other value, the bit keeps its value.
- R9: A write to address 1 lowers the routed line for every rev_sel value. It clears cause bit 0 only when rev_sel equals 1. Cause bit 0 cannot be written by software.
- R10: Bits [2:0] of address 3 select which irq_out bit carries the interrupt. At most one line is high. Changing the field while the interrupt is pending moves it to the new line at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rev_sel | input | 3 | Architecture revision selector |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 count, 1 compare, 2 cause, 3 interrupt control |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| irq_out | output | 8 | Interrupt line vector |

## Verification
The bench lets the count wrap through 0xFFFFFFFF into a compare value of 0. A design that tested the unwrapped sum would never fire there.

It holds the count frozen for a long stretch with a match only one step away, then releases it. A design that kept counting in the background would show a jump on release, and a design that still evaluated matches while frozen would raise a line too early.

It switches rev_sel between setting the pending flag and acknowledging it, which exposes a design that decodes the revision only once. It also moves the routing field while a line is high, which catches a design that latches the line index when the match fires.

// File: rtl/cct_pkg.sv
package cct_pkg;
  typedef enum logic [1:0] {
    SEL_COUNT   = 2'd0,
    SEL_COMPARE = 2'd1,
    SEL_CAUSE   = 2'd2,
    SEL_INTCTL  = 2'd3
  } reg_sel_e;

  localparam int CAUSE_PEND_BIT   = 0;
  localparam int CAUSE_FREEZE_BIT = 1;
  localparam logic [2:0] REV_WITH_PEND = 3'd1;

  // The revision whose cause register tracks the pending flag
  function automatic logic rev_tracks_pend(input logic [2:0] rev);
    return rev == REV_WITH_PEND;
  endfunction
endpackage

// File: rtl/cct_prescaler.sv
module cct_prescaler #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  generate
    if (DIV <= 1) begin : g_every
      assign tick = 1'b1;
    end else begin : g_div
      localparam int PW = $clog2(DIV);
      localparam logic [PW-1:0] LAST = PW'(DIV - 1);
      logic [PW-1:0] phase;

      always_ff @(posedge clk) begin
        if (!rst_n)             phase <= '0;
        else if (phase == LAST) phase <= '0;
        else                    phase <= phase + PW'(1);
      end

      assign tick = (phase == LAST);

      // R2
      tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/cct_counter.sv
module cct_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         freeze,
  input  logic         cnt_wr,
  input  logic [W-1:0] cnt_wdata,
  input  logic         cmp_wr,
  input  logic [W-1:0] cmp_wdata,
  output logic [W-1:0] count,
  output logic [W-1:0] compare,
  output logic         match_evt
);
  function automatic logic [W-1:0] step(input logic [W-1:0] v);
    return v + W'(1);
  endfunction

  logic advance;
  assign advance   = tick && !freeze && !cnt_wr;
  assign match_evt = advance && (step(count) == compare);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count   <= '0;
      compare <= '0;
    end else begin
      if (cnt_wr)       count <= cnt_wdata;
      else if (advance) count <= step(count);
      if (cmp_wr)       compare <= cmp_wdata;
    end
  end

  // R3
  count_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> count == $past(cnt_wdata));
  // R4
  freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze && !cnt_wr) |=> count == $past(count));
  // R2
  single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_wr |=> (count == $past(count)) || (count == $past(count) + W'(1)));
endmodule

// File: rtl/cct_irq_route.sv
module cct_irq_route #(
  parameter int LINES = 8,
  localparam int RW = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       rev,
  input  logic [RW-1:0]    route,
  input  logic             match_evt,
  input  logic             cmp_wr,
  output logic             pend_flag,
  output logic             line_pend,
  output logic [LINES-1:0] irq_out
);
  import cct_pkg::*;

  logic tracks;
  assign tracks = rev_tracks_pend(rev);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_pend <= 1'b0;
      pend_flag <= 1'b0;
    end else if (cmp_wr) begin
      line_pend <= 1'b0;
      if (tracks) pend_flag <= 1'b0;
    end else if (match_evt) begin
      line_pend <= 1'b1;
      if (tracks) pend_flag <= 1'b1;
    end
  end

  generate
    for (genvar i = 0; i < LINES; i++) begin : g_line
      assign irq_out[i] = line_pend && (route == RW'(i));
    end
  endgenerate

  // R7
  match_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (match_evt && !cmp_wr) |=> irq_out != '0);
  // R8
  pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (match_evt && !cmp_wr && tracks) |=> pend_flag);
  // R8
  pend_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tracks && !cmp_wr) |=> pend_flag == $past(pend_flag));
  // R9
  ack_lower_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_wr |=> irq_out == '0);
  // R9
  ack_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_wr && !tracks) |=> pend_flag == $past(pend_flag));
  // R10
  one_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_out));
endmodule

// File: rtl/cct_timer.sv
module cct_timer #(
  parameter int CNT_W        = 32,
  parameter int LINES        = 8,
  parameter int PRESCALE_DIV = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       rev_sel,
  input  logic             reg_wr,
  input  logic [1:0]       reg_addr,
  input  logic [CNT_W-1:0] reg_wdata,
  output logic [CNT_W-1:0] reg_rdata,
  output logic [LINES-1:0] irq_out
);
  import cct_pkg::*;
  localparam int RW = $clog2(LINES);

  logic             tick, freeze, match_evt, pend_flag, line_pend;
  logic [RW-1:0]    route;
  logic [CNT_W-1:0] count, compare;
  logic             cnt_wr, cmp_wr, cause_wr, ictl_wr;

  assign cnt_wr   = reg_wr && (reg_addr == SEL_COUNT);
  assign cmp_wr   = reg_wr && (reg_addr == SEL_COMPARE);
  assign cause_wr = reg_wr && (reg_addr == SEL_CAUSE);
  assign ictl_wr  = reg_wr && (reg_addr == SEL_INTCTL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      freeze <= 1'b0;
      route  <= '0;
    end else begin
      if (cause_wr) freeze <= reg_wdata[CAUSE_FREEZE_BIT];
      if (ictl_wr)  route  <= reg_wdata[RW-1:0];
    end
  end

  cct_prescaler #(.DIV(PRESCALE_DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  cct_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .freeze(freeze),
    .cnt_wr(cnt_wr), .cnt_wdata(reg_wdata),
    .cmp_wr(cmp_wr), .cmp_wdata(reg_wdata),
    .count(count), .compare(compare), .match_evt(match_evt)
  );

  cct_irq_route #(.LINES(LINES)) u_irq (
    .clk(clk), .rst_n(rst_n), .rev(rev_sel), .route(route),
    .match_evt(match_evt), .cmp_wr(cmp_wr),
    .pend_flag(pend_flag), .line_pend(line_pend), .irq_out(irq_out)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_sel_e'(reg_addr))
      SEL_COUNT:   reg_rdata = count;
      SEL_COMPARE: reg_rdata = compare;
      SEL_CAUSE: begin
        reg_rdata[CAUSE_PEND_BIT]   = pend_flag;
        reg_rdata[CAUSE_FREEZE_BIT] = freeze;
      end
      default:     reg_rdata[RW-1:0] = route;
    endcase
  end

  // R6
  frozen_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze && !cmp_wr) |=> (line_pend == $past(line_pend)) && (pend_flag == $past(pend_flag)));
  // R7
  match_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(line_pend) |-> count == compare);
  // R10
  route_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_pend |-> irq_out[route]);
endmodule

// File: tb/cct_timer_test.sv
`timescale 1ns/1ps
module cct_timer_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [2:0]  rev_sel = 3'd1;
  logic        reg_wr = 0;
  logic [1:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic [7:0]  irq_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  cct_timer uut (
    .clk(clk), .rst_n(rst_n), .rev_sel(rev_sel), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_out(irq_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
    #1;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wait_irq(input int maxc, output int cyc);
    cyc = -1;
    for (int i = 0; i < maxc; i++) begin
      @(negedge clk); #1;
      if (irq_out != 0) begin cyc = i; break; end
    end
  endtask

  task automatic t_reset();
    logic [31:0] v;
    repeat (3) @(negedge clk);
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], v);
      check("R1 register reset", v, 0);
    end
    check("R1 irq reset", {24'b0, irq_out}, 0);
    rst_n = 1;
  endtask

  task automatic t_rate_wrap();
    logic [31:0] prev, cur;
    int changes = 0;
    wr(2'd2, 32'h2);
    wr(2'd1, 32'h1000);
    wr(2'd0, 32'hFFFF_FFF8);
    wr(2'd2, 32'h0);
    rd(2'd0, prev);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk); #1;
      rd(2'd0, cur);
      if (cur != prev) begin
        changes++;
        check("R2 step by one", cur, prev + 32'd1);
      end
      prev = cur;
    end
    check("R2 ticks in 40 cycles", changes, 10);
    check("R2 wrapped value", prev, 32'h2);
  endtask

  task automatic t_count_write();
    logic [31:0] v;
    wr(2'd0, 32'h1234_5678);
    rd(2'd0, v);
    check("R3 count write next cycle", v, 32'h1234_5678);
  endtask

  task automatic t_freeze_resume();
    logic [31:0] held, v;
    wr(2'd2, 32'h2);
    rd(2'd0, held);
    repeat (60) @(negedge clk);
    #1;
    rd(2'd0, v);
    check("R4 frozen count held", v, held);
    rd(2'd2, v);
    check("R4 freeze bit reads back", v & 32'h2, 32'h2);
    wr(2'd2, 32'h0);
    rd(2'd0, v);
    check("R5 resume from held", v, held);
    repeat (8) @(negedge clk);
    #1;
    rd(2'd0, v);
    check("R5 no jump after resume", v, held + 32'd2);
  endtask

  task automatic t_frozen_match();
    logic [31:0] v;
    int cyc;
    rev_sel = 3'd1;
    wr(2'd2, 32'h2);
    wr(2'd3, 32'd4);
    wr(2'd0, 32'h100);
    wr(2'd1, 32'h101);
    repeat (50) @(negedge clk);
    #1;
    check("R6 no line while frozen", {24'b0, irq_out}, 0);
    rd(2'd2, v);
    check("R6 no pend while frozen", v & 32'h1, 0);
    wr(2'd2, 32'h0);
    wait_irq(20, cyc);
    check("R6 match after unfreeze", {24'b0, irq_out}, 32'h10);
    rd(2'd0, v);
    check("R7 count equals compare at rise", v, 32'h101);
    wr(2'd1, 32'h0);
  endtask

  task automatic t_match_rev1();
    logic [31:0] v;
    int cyc;
    rev_sel = 3'd1;
    wr(2'd2, 32'h2);
    wr(2'd3, 32'd3);
    wr(2'd0, 32'h50);
    wr(2'd1, 32'h54);
    wr(2'd2, 32'h0);
    wait_irq(100, cyc);
    check("R7 routed line raised", {24'b0, irq_out}, 32'h08);
    rd(2'd0, v);
    check("R7 rise on equal edge", v, 32'h54);
    rd(2'd2, v);
    check("R8 pend set rev1", v & 32'h1, 1);
    repeat (20) @(negedge clk);
    #1;
    check("R7 line held past match", {24'b0, irq_out}, 32'h08);
    wr(2'd2, 32'h1);
    rd(2'd2, v);
    check("R9 pend bit not writable", v & 32'h1, 1);
    wr(2'd3, 32'd6);
    check("R10 line moves with route", {24'b0, irq_out}, 32'h40);
    wr(2'd1, 32'h7000_0000);
    check("R9 compare write lowers", {24'b0, irq_out}, 0);
    rd(2'd2, v);
    check("R9 pend cleared rev1", v & 32'h1, 0);
  endtask

  task automatic t_match_rev2();
    logic [31:0] v;
    int cyc;
    rev_sel = 3'd2;
    wr(2'd2, 32'h2);
    wr(2'd3, 32'd0);
    wr(2'd0, 32'hFFFF_FFFD);
    wr(2'd1, 32'h0);
    wr(2'd2, 32'h0);
    wait_irq(100, cyc);
    check("R10 line 0 selected", {24'b0, irq_out}, 32'h01);
    rd(2'd0, v);
    check("R2 wrap to zero matches", v, 32'h0);
    rd(2'd2, v);
    check("R8 no pend rev2", v & 32'h1, 0);
    wr(2'd1, 32'h7000_0000);
    check("R9 lower rev2", {24'b0, irq_out}, 0);
    // set pend under rev1, acknowledge under rev2
    rev_sel = 3'd1;
    wr(2'd2, 32'h2);
    wr(2'd0, 32'h200);
    wr(2'd1, 32'h201);
    wr(2'd2, 32'h0);
    wait_irq(100, cyc);
    rd(2'd2, v);
    check("R8 pend set before switch", v & 32'h1, 1);
    rev_sel = 3'd2;
    wr(2'd1, 32'h7000_0000);
    check("R9 lower after switch", {24'b0, irq_out}, 0);
    rd(2'd2, v);
    check("R9 pend kept rev2", v & 32'h1, 1);
  endtask

  initial begin
    t_reset();
    t_rate_wrap();
    t_count_write();
    t_freeze_resume();
    t_frozen_match();
    t_match_rev1();
    t_match_rev2();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule